// File: doc/BRIEF.md
# Two-Cluster Operand Network with Mirrored Register Files

This block delivers source operands to a four-ALU execution core that is split into two clusters of two ALUs. Each cluster reads only its own copy of the register file, and every result is written into both copies in the same cycle, so the copies never differ. A result reaches an ALU in its own cluster in the cycle after it is produced, through a direct forwarding path. The other cluster has no forwarding path to it and sees the value one cycle later, through its register-file copy. For each ALU input the block selects the right value and reports whether that value can be delivered yet.

Each cycle the core presents one issue group of up to four instructions, one per slot, with two source register numbers per slot. In the same cycle the ALUs present the results of the group issued one cycle earlier: a valid bit, a destination register and a data word per slot. Slot numbers give program order, and a higher slot is younger. Slots 0 and 1 belong to cluster 0, and slots 2 and 3 to cluster 1. The block never back-pressures: results are always accepted. An operand that is not yet reachable drives its ready bit low and raises `grp_hold`. The issue logic must then hold the group and present it again. The issue logic is expected not to issue a group whose slots depend on one another.

Top module: `cluster_operand_net`

## Requirements
- R1: After reset every register holds zero in both copies, and with no results pending every operand reads zero with its ready bit high.
- R2: A result presented with its valid bit high in cycle t is readable from the register file by both clusters from cycle t+2 on, and both copies always return the same value for the same register.
- R3: A result presented in cycle t by a slot of cluster c is delivered in cycle t+1 to any operand of a cluster-c slot that names its destination register, with the ready bit high.
- R4: In cycle t+1 an operand of a valid slot in the other cluster that names that destination register has its ready bit low. In cycle t+2 the same operand is ready with the value.
- R5: When several slots present results for the same register in one cycle, the highest-numbered slot's value is the one forwarded and the one kept in the register file.
- R6: If the youngest writer of a register in the previous cycle belongs to the other cluster, an operand naming that register is not ready, even when an older writer in its own cluster matches.
- R7: An operand of a slot whose issue valid bit is low always reports ready. `grp_hold` is high exactly when some operand reports not ready.
- R8: A result whose valid bit is low changes no register and is not forwarded.
- R9: Slot i belongs to cluster i / 2 (integer division). This mapping decides which results count as local to a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 4 | Slot holds an instruction this cycle |
| iss_src | input | 4x2x5 | Source register numbers, [slot][operand] |
| res_valid | input | 4 | Slot result is valid this cycle |
| res_dest | input | 4x5 | Result destination register per slot |
| res_data | input | 4x32 | Result value per slot |
| opnd_data | output | 4x2x32 | Selected operand value, [slot][operand] |
| opnd_rdy | output | 4x2 | Operand can be delivered this cycle |
| grp_hold | output | 1 | Some operand of the group is not ready |

## Verification
The hardest case to reach is one where a register has several writers in the same cycle and those writers sit in both clusters. In that case the ready bit depends on which writer is youngest, not on whether any local match exists. Directed cycles place an older local writer beneath a younger remote one, and same-cluster writers that collide. A long random phase then draws every destination and source from a pool of eight registers, so that collisions and cross-cluster hits occur in most cycles. A behavioural model of the architectural register state and the previous results is compared against every operand and every ready bit on each clock.

// File: rtl/cop_pkg.sv
package cop_pkg;
  parameter int unsigned COP_ALUS   = 4;
  parameter int unsigned COP_CLUS   = 2;
  parameter int unsigned COP_REGS   = 32;
  parameter int unsigned COP_DATA_W = 32;
  localparam int unsigned COP_SRCS  = 2;

  // cluster that owns a given slot
  function automatic int unsigned slot_cluster(input int unsigned slot, input int unsigned per_clu);
    return slot / per_clu;
  endfunction
endpackage

// File: rtl/cop_result_stage.sv
module cop_result_stage #(
  parameter int NUM_ALU = 4,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_ALU-1:0]                res_valid,
  input  logic [NUM_ALU-1:0][REG_W-1:0]     res_dest,
  input  logic [NUM_ALU-1:0][DATA_W-1:0]    res_data,
  output logic [NUM_ALU-1:0]                q_vld,
  output logic [NUM_ALU-1:0][REG_W-1:0]     q_dst,
  output logic [NUM_ALU-1:0][DATA_W-1:0]    q_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= '0;
      q_dst <= '0;
      q_val <= '0;
    end else begin
      q_vld <= res_valid;
      q_dst <= res_dest;
      q_val <= res_data;
    end
  end

  for (genvar s = 0; s < NUM_ALU; s++) begin : g_chk
    AST_IDLE_RESULT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid[s] |=> !q_vld[s]); // R8
  end
endmodule

// File: rtl/cop_rf_replica.sv
module cop_rf_replica #(
  parameter int NUM_REG = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_WR  = 4,
  parameter int NUM_RD  = 4,
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_WR-1:0]               wr_en,
  input  logic [NUM_WR-1:0][REG_W-1:0]    wr_addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0]   wr_data,
  input  logic [NUM_RD-1:0][REG_W-1:0]    rd_addr,
  output logic [NUM_RD-1:0][DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] mem [NUM_REG];

  // later ports override earlier ones: highest slot is youngest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REG; r++) mem[r] <= '0;
    end else begin
      for (int w = 0; w < NUM_WR; w++)
        if (wr_en[w]) mem[wr_addr[w]] <= wr_data[w];
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end

  AST_YOUNGEST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[NUM_WR-1] |=> mem[$past(wr_addr[NUM_WR-1])] == $past(wr_data[NUM_WR-1])); // R5
endmodule

// File: rtl/cop_operand_sel.sv
module cop_operand_sel #(
  parameter int NUM_ALU     = 4,
  parameter int ALU_PER_CLU = 2,
  parameter int CLU_ID      = 0,
  parameter int REG_W       = 5,
  parameter int DATA_W      = 32,
  localparam int SLOT_W     = $clog2(NUM_ALU)
) (
  input  logic                               use_i,
  input  logic [REG_W-1:0]                   src_i,
  input  logic [NUM_ALU-1:0]                 fwd_vld,
  input  logic [NUM_ALU-1:0][REG_W-1:0]      fwd_dst,
  input  logic [ALU_PER_CLU-1:0][DATA_W-1:0] loc_val,
  input  logic [DATA_W-1:0]                  rf_val,
  output logic [DATA_W-1:0]                  data_o,
  output logic                               rdy_o
);
  logic              hit;
  logic [SLOT_W-1:0] hit_slot;
  logic              hit_local;

  // youngest matching producer across both clusters
  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    for (int s = 0; s < NUM_ALU; s++) begin
      if (fwd_vld[s] && fwd_dst[s] == src_i) begin
        hit      = 1'b1;
        hit_slot = SLOT_W'(s);
      end
    end
  end

  assign hit_local = (cop_pkg::slot_cluster(int'(hit_slot), ALU_PER_CLU) == CLU_ID);

  // (ALU_PER_CLU + 1)-input mux: local results plus the replica read
  always_comb begin
    data_o = rf_val;
    if (hit && hit_local) begin
      for (int l = 0; l < ALU_PER_CLU; l++)
        if (hit_slot == SLOT_W'(CLU_ID * ALU_PER_CLU + l)) data_o = loc_val[l];
    end
    rdy_o = !use_i || !hit || hit_local;
  end
endmodule

// File: rtl/cluster_operand_net.sv
module cluster_operand_net #(
  parameter int NUM_ALU = cop_pkg::COP_ALUS,
  parameter int NUM_CLU = cop_pkg::COP_CLUS,
  parameter int NUM_REG = cop_pkg::COP_REGS,
  parameter int DATA_W  = cop_pkg::COP_DATA_W,
  localparam int REG_W  = $clog2(NUM_REG),
  localparam int NSRC   = cop_pkg::COP_SRCS
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [NUM_ALU-1:0]                        iss_valid,
  input  logic [NUM_ALU-1:0][NSRC-1:0][REG_W-1:0]   iss_src,
  input  logic [NUM_ALU-1:0]                        res_valid,
  input  logic [NUM_ALU-1:0][REG_W-1:0]             res_dest,
  input  logic [NUM_ALU-1:0][DATA_W-1:0]            res_data,
  output logic [NUM_ALU-1:0][NSRC-1:0][DATA_W-1:0]  opnd_data,
  output logic [NUM_ALU-1:0][NSRC-1:0]              opnd_rdy,
  output logic                                      grp_hold
);
  localparam int APC    = NUM_ALU / NUM_CLU;
  localparam int RD_CLU = NSRC * APC;

  logic [NUM_ALU-1:0]                 q_vld;
  logic [NUM_ALU-1:0][REG_W-1:0]      q_dst;
  logic [NUM_ALU-1:0][DATA_W-1:0]     q_val;
  logic [NUM_CLU-1:0][RD_CLU-1:0][DATA_W-1:0] rf_rd;

  cop_result_stage #(.NUM_ALU(NUM_ALU), .REG_W(REG_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_dest(res_dest), .res_data(res_data),
    .q_vld(q_vld), .q_dst(q_dst), .q_val(q_val)
  );

  for (genvar c = 0; c < NUM_CLU; c++) begin : g_clu
    logic [RD_CLU-1:0][REG_W-1:0] ra;

    for (genvar l = 0; l < APC; l++) begin : g_alu
      for (genvar k = 0; k < NSRC; k++) begin : g_op
        assign ra[l*NSRC+k] = iss_src[c*APC+l][k];

        cop_operand_sel #(
          .NUM_ALU(NUM_ALU), .ALU_PER_CLU(APC), .CLU_ID(c),
          .REG_W(REG_W), .DATA_W(DATA_W)
        ) u_sel (
          .use_i(iss_valid[c*APC+l]),
          .src_i(iss_src[c*APC+l][k]),
          .fwd_vld(q_vld),
          .fwd_dst(q_dst),
          .loc_val(q_val[c*APC +: APC]),
          .rf_val(rf_rd[c][l*NSRC+k]),
          .data_o(opnd_data[c*APC+l][k]),
          .rdy_o(opnd_rdy[c*APC+l][k])
        );
      end
    end

    // every replica takes every write (broadcast)
    cop_rf_replica #(
      .NUM_REG(NUM_REG), .DATA_W(DATA_W), .NUM_WR(NUM_ALU), .NUM_RD(RD_CLU)
    ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(q_vld), .wr_addr(q_dst), .wr_data(q_val),
      .rd_addr(ra), .rd_data(rf_rd[c])
    );
  end

  assign grp_hold = ~&opnd_rdy;

  AST_REPLICAS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src[0][0] == iss_src[APC][0]) |-> rf_rd[0][0] == rf_rd[1][0]); // R2

  AST_LOCAL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(res_valid[NUM_ALU-1]) && $past(res_dest[NUM_ALU-1]) == iss_src[NUM_ALU-2][0])
    |-> opnd_rdy[NUM_ALU-2][0] && opnd_data[NUM_ALU-2][0] == $past(res_data[NUM_ALU-1])); // R3

  AST_REMOTE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(res_valid[NUM_ALU-1]) && $past(res_dest[NUM_ALU-1]) == iss_src[0][0] && iss_valid[0])
    |-> !opnd_rdy[0][0]); // R4

  AST_IDLE_SLOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid[0] |-> &opnd_rdy[0]); // R7

  AST_QUIET_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(res_valid) == '0) |-> !grp_hold); // R8
endmodule

// File: tb/cluster_operand_net_test.sv
module cluster_operand_net_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]                 iss_valid;
  logic [3:0][1:0][4:0]       iss_src;
  logic [3:0]                 res_valid;
  logic [3:0][4:0]            res_dest;
  logic [3:0][31:0]           res_data;
  logic [3:0][1:0][31:0]      opnd_data;
  logic [3:0][1:0]            opnd_rdy;
  logic                       grp_hold;

  cluster_operand_net uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_src(iss_src),
    .res_valid(res_valid), .res_dest(res_dest), .res_data(res_data),
    .opnd_data(opnd_data), .opnd_rdy(opnd_rdy), .grp_hold(grp_hold)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string phase_tag = "";

  // model: register state as held by the file, plus last cycle's results
  logic [31:0] arch_rf [32];
  bit          pv [4];
  int          pd [4];
  logic [31:0] pdat [4];

  task automatic report(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_now();
    bit exp_hold = 0;
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 2; k++) begin
        int s = int'(iss_src[i][k]);
        int y = -1;
        int nm = 0;
        bit loc_old = 0;
        logic [31:0] truth = arch_rf[s];
        bit er;
        string tag;
        for (int j = 0; j < 4; j++)
          if (pv[j] && pd[j] == s) begin
            y = j; nm++; truth = pdat[j];
          end
        for (int j = 0; j < 4; j++)
          if (pv[j] && pd[j] == s && j != y && j / 2 == i / 2) loc_old = 1;
        er = !iss_valid[i] || y < 0 || (y / 2 == i / 2);
        if (!iss_valid[i]) tag = "R7";
        else if (y < 0) tag = "R2";
        else if (er) tag = (nm > 1) ? "R5" : "R3";
        else tag = loc_old ? "R6" : "R4";
        tag = {phase_tag, " ", tag};
        report(tag, $sformatf("rdy[%0d][%0d]", i, k), 32'(opnd_rdy[i][k]), 32'(er));
        if (er && iss_valid[i])
          report(tag, $sformatf("data[%0d][%0d]", i, k), opnd_data[i][k], truth);
        if (!er) exp_hold = 1;
      end
    end
    report({phase_tag, " R7"}, "grp_hold", 32'(grp_hold), 32'(exp_hold));
  endtask

  // inputs are driven at the falling edge; check 1ns later; model follows the rising edge
  task automatic cyc();
    #1;
    check_now();
    @(posedge clk);
    for (int j = 0; j < 4; j++) if (pv[j]) arch_rf[pd[j]] = pdat[j];
    for (int j = 0; j < 4; j++) begin
      pv[j] = res_valid[j]; pd[j] = int'(res_dest[j]); pdat[j] = res_data[j];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = '0; iss_src = '0; res_valid = '0; res_dest = '0; res_data = '0;
  endtask

  task automatic put_res(input int slot, input int dst, input logic [31:0] val);
    res_valid[slot] = 1'b1; res_dest[slot] = 5'(dst); res_data[slot] = val;
  endtask

  task automatic read(input int slot, input int a, input int b);
    iss_valid[slot] = 1'b1; iss_src[slot][0] = 5'(a); iss_src[slot][1] = 5'(b);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) arch_rf[r] = '0;
    for (int j = 0; j < 4; j++) begin pv[j] = 0; pd[j] = 0; pdat[j] = '0; end
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    phase_tag = "R1";
    for (int i = 0; i < 4; i++) read(i, i * 2 + 3, 31 - i);
    cyc();

    // R3 R9: slot 0 (cluster 0) produces r5
    phase_tag = "R9";
    idle(); put_res(0, 5, 32'h1111_0005); cyc();
    idle(); read(0, 5, 1); read(1, 2, 5); read(2, 5, 5); read(3, 6, 5); cyc();
    // R4 R2: remote side now reads it through its own replica
    phase_tag = "R4";
    idle(); read(2, 5, 5); read(3, 5, 0); read(0, 5, 5); cyc();

    // R5: same-cycle writers in both clusters
    phase_tag = "R5";
    idle(); put_res(0, 7, 32'hAAAA_0007); put_res(1, 7, 32'hBBBB_0007);
    put_res(2, 9, 32'hDDDD_0009); put_res(3, 9, 32'hEEEE_0009); cyc();
    idle(); read(0, 7, 9); read(1, 9, 7); read(2, 7, 9); read(3, 9, 7); cyc();
    idle(); read(0, 7, 9); read(1, 9, 7); read(2, 7, 9); read(3, 9, 7); cyc();

    // R6: younger remote writer shadows older local one
    phase_tag = "R6";
    idle(); put_res(1, 8, 32'hCCCC_0008); put_res(2, 8, 32'hFFFF_0008); cyc();
    idle(); read(0, 8, 7); read(3, 8, 8); read(1, 8, 9); cyc();
    idle(); read(0, 8, 8); read(3, 8, 8); cyc();

    // R8: a result with valid low is ignored
    phase_tag = "R8";
    idle(); res_dest[1] = 5'd7; res_data[1] = 32'hDEAD_BEEF; res_dest[3] = 5'd7; res_data[3] = 32'hDEAD_BEEF; cyc();
    idle(); read(0, 7, 7); read(2, 7, 7); cyc();
    idle(); read(1, 7, 7); read(3, 7, 7); cyc();

    // R7: idle slot stays ready despite a remote hit
    phase_tag = "R7";
    idle(); put_res(3, 10, 32'h0000_0A0A); cyc();
    idle(); iss_src[0][0] = 5'd10; iss_src[0][1] = 5'd10; read(1, 1, 2); read(2, 10, 3); cyc();

    // random traffic over a small register pool
    phase_tag = "RND";
    for (int n = 0; n < 4000; n++) begin
      idle();
      for (int i = 0; i < 4; i++) begin
        iss_valid[i] = 1'($urandom_range(0, 3) != 0);
        iss_src[i][0] = 5'($urandom_range(0, 7));
        iss_src[i][1] = 5'($urandom_range(0, 7));
        res_valid[i] = 1'($urandom_range(0, 2) != 0);
        res_dest[i] = 5'($urandom_range(0, 7));
        res_data[i] = $urandom;
      end
      cyc();
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule